// File: doc/BRIEF.md
# Load/Store Byte Alignment Stage

This stage sits between an execute unit and a data cache whose port is one doubleword (eight byte lanes) wide. A store arrives with its register value, and the stage steers that value's bytes onto the cache lanes. It can optionally reverse the byte order. The lane steering is a rotation by the low three address bits, so bytes that spill past the end of the doubleword land in the low lanes. A load goes the other way. The stage collects the returned lanes, rotates them down to the register's low end, optionally reverses them, and fills the upper bytes with zeros or with copies of the sign bit.

An access whose bytes cross a doubleword boundary becomes two cache requests in consecutive cycles, each with its own byte-enable mask. The stage then waits for two acknowledgements and produces exactly one write-back. While an access is in flight, the stage holds off the upstream stage with a stall signal.

Top module: `ls_align_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, stallOut, cacheValid and wbValid are 0.
- R2: A request is taken in a cycle where reqValid is 1 and stallOut is 0. From the next cycle, stallOut stays 1 until the cycle in which wbValid is 1; in that cycle stallOut is 0.
- R3: reqSize codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. With offset = reqAddr[2:0] and n bytes, the access is split when offset + n > 8.
- R4: In the cycle after acceptance, the first request is presented. cacheValid is 1, cacheAddr is reqAddr with its low 3 bits cleared, cacheIsLoad matches the request, and cacheByteEn bit k is set for offset <= k < min(8, offset + n).
- R5: A split access presents its second request in the very next cycle. cacheAddr is 8 higher than the first request's address, and cacheByteEn bit k is set for k < offset + n - 8. An access that is not split presents only one request.
- R6: Store write data on lane k (bits 8k+7..8k) is register byte r = (k - offset) mod 8 when reversal is off, and register byte n-1-r when it is on. Lanes with r >= n carry zero. The same word goes with both requests of a split store. For loads, the write data is zero.
- R7: Byte j (j < n) of a load result is the memory byte at address reqAddr + j when reversal is off, and at reqAddr + n-1-j when it is on. Lanes at or above the offset come from the first acknowledged doubleword; lower lanes come from the second.
- R8: Load result bytes j >= n are zero when reqSignExt is 0. When reqSignExt is 1, they are copies of bit 7 of result byte n-1, taken after reversal.
- R9: wbValid is 1 for exactly one cycle, the cycle after the acknowledgement that completes the access. That is the first acknowledgement for an aligned access and the second for a split one. For stores, wbData is zero. An acknowledgement never arrives in the same cycle as the request it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upstream access request |
| reqIsLoad | input | 1 | 1 = load, 0 = store |
| reqAddr | input | 32 | Byte address of the access |
| reqSize | input | 2 | Size code, 1 << code bytes |
| reqReverse | input | 1 | Reverse byte order |
| reqSignExt | input | 1 | Sign-extend load result |
| reqData | input | 64 | Store register value |
| stallOut | output | 1 | Stage busy, hold upstream |
| cacheValid | output | 1 | Cache request strobe |
| cacheIsLoad | output | 1 | Cache request is a read |
| cacheAddr | output | 32 | Doubleword-aligned cache address |
| cacheByteEn | output | 8 | Lane enables of the request |
| cacheWrData | output | 64 | Lane-aligned store data |
| cacheAck | input | 1 | Cache acknowledgement of one request |
| cacheRdData | input | 64 | Read data accompanying cacheAck |
| wbValid | output | 1 | One completion per access |
| wbData | output | 64 | Formatted load result |

## Verification
The assertions check several properties on every cycle. Back-to-back cache requests must address adjacent doublewords. A second request never enables the top lane, and every request enables at least one lane. Write-backs last one cycle and always follow an acknowledgement. A new request only goes out after an accepted one. A zero-extended byte load has a clear upper word. The lane contents themselves are shown only by the bench. It sweeps every offset, size, reversal, extension and direction, with varied acknowledgement latency. These scenarios prove the rotation and reversal mapping, the merging of the two load pieces, and the exact cycle of the write-back.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND_LO,
    ST_SEND_HI,
    ST_WAIT
  } lsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture an accepted request
    logic sendLo;    // present the first doubleword request
    logic sendHi;    // present the second doubleword request
    logic keepLo;    // hold the first returned piece of a split load
    logic finish;    // last acknowledgement, produce the write-back
  } lsStrobe_t;
endpackage

// File: rtl/ls_align_ctrl.sv
module ls_align_ctrl
  import ls_align_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      isSplit,
  input  logic      cacheAck,
  output lsStrobe_t strb,
  output logic      stallOut,
  output logic      cacheValid
);
  lsState_e state, stateNext;
  logic     oneAckSeen;
  logic     ackLive;

  // acknowledgements can only answer a request already issued
  assign ackLive  = cacheAck && (state == ST_SEND_HI || state == ST_WAIT);

  assign stallOut   = (state != ST_IDLE);
  assign cacheValid = (state == ST_SEND_LO) || (state == ST_SEND_HI);

  always_comb begin
    strb          = '0;
    strb.latchReq = reqValid && (state == ST_IDLE);
    strb.sendLo   = (state == ST_SEND_LO);
    strb.sendHi   = (state == ST_SEND_HI);
    strb.keepLo   = ackLive && isSplit && !oneAckSeen;
    strb.finish   = ackLive && (!isSplit || oneAckSeen);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (reqValid) stateNext = ST_SEND_LO;
      ST_SEND_LO: stateNext = isSplit ? ST_SEND_HI : ST_WAIT;
      ST_SEND_HI: stateNext = ST_WAIT;
      ST_WAIT:    if (strb.finish) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      oneAckSeen <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.latchReq)    oneAckSeen <= 1'b0;
      else if (strb.keepLo) oneAckSeen <= 1'b1;
    end
  end

  // R2: a request burst only starts after a taken upstream request
  p_issue_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cacheValid) |-> $past(reqValid && !stallOut));
endmodule

// File: rtl/ls_align_dp.sv
module ls_align_dp
  import ls_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int SZ_W  = $clog2(OFF_W + 1),
  localparam int CNT_W = OFF_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lsStrobe_t         strb,
  input  logic              reqIsLoad,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SZ_W-1:0]   reqSize,
  input  logic              reqReverse,
  input  logic              reqSignExt,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] cacheRdData,
  output logic              isSplit,
  output logic              isLoadQ,
  output logic [ADDR_W-1:0] cacheAddr,
  output logic [LANES-1:0]  cacheByteEn,
  output logic [DATA_W-1:0] cacheWrData,
  output logic              wbValid,
  output logic [DATA_W-1:0] wbData
);
  logic [ADDR_W-OFF_W-1:0] dwQ;
  logic [OFF_W-1:0]        offQ;
  logic [SZ_W-1:0]         sizeQ;
  logic                    revQ, sextQ;
  logic [DATA_W-1:0]       dataQ, loPieceQ;

  logic [CNT_W-1:0]  nBytes, endSum;
  logic [OFF_W-1:0]  lastIdx;
  logic [LANES-1:0]  beLo, beHi;
  logic [DATA_W-1:0] storeWord, merged, rawWord, loadWord, loSrc;
  logic              signBit;

  assign nBytes  = CNT_W'(1) << sizeQ;
  assign endSum  = CNT_W'(offQ) + nBytes;
  assign isSplit = endSum > CNT_W'(LANES);
  assign lastIdx = OFF_W'(nBytes - CNT_W'(1));
  assign loSrc   = isSplit ? loPieceQ : cacheRdData;

  // per memory lane: masks, store steering, load piece merge
  for (genvar k = 0; k < LANES; k++) begin : g_memLane
    logic [OFF_W-1:0] rel, stSrc;
    logic             inAcc;
    assign rel     = OFF_W'(k) - offQ;
    assign inAcc   = CNT_W'(rel) < nBytes;
    assign stSrc   = revQ ? (lastIdx - rel) : rel;
    assign beLo[k] = (OFF_W'(k) >= offQ) && (CNT_W'(k) < endSum);
    assign beHi[k] = (CNT_W'(k) + CNT_W'(LANES)) < endSum;
    assign storeWord[8*k +: 8] = inAcc ? dataQ[{stSrc, 3'b000} +: 8] : 8'h00;
    assign merged[8*k +: 8]    = (OFF_W'(k) >= offQ) ? loSrc[8*k +: 8]
                                                     : cacheRdData[8*k +: 8];
  end

  // per register lane: one select doing rotate and reverse together
  for (genvar j = 0; j < LANES; j++) begin : g_regLane
    logic [OFF_W-1:0] ldSrc;
    assign ldSrc = revQ ? (offQ + lastIdx - OFF_W'(j)) : (offQ + OFF_W'(j));
    assign rawWord[8*j +: 8] = merged[{ldSrc, 3'b000} +: 8];
  end

  assign signBit = rawWord[{lastIdx, 3'b111}];

  for (genvar j = 0; j < LANES; j++) begin : g_extLane
    assign loadWord[8*j +: 8] = (CNT_W'(j) < nBytes) ? rawWord[8*j +: 8]
                                                     : {8{sextQ & signBit}};
  end

  assign cacheAddr   = strb.sendHi ? {dwQ + 1'b1, {OFF_W{1'b0}}} : {dwQ, {OFF_W{1'b0}}};
  assign cacheByteEn = strb.sendLo ? beLo : (strb.sendHi ? beHi : '0);
  assign cacheWrData = isLoadQ ? '0 : storeWord;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dwQ      <= '0;
      offQ     <= '0;
      sizeQ    <= '0;
      revQ     <= 1'b0;
      sextQ    <= 1'b0;
      isLoadQ  <= 1'b0;
      dataQ    <= '0;
      loPieceQ <= '0;
      wbValid  <= 1'b0;
      wbData   <= '0;
    end else begin
      if (strb.latchReq) begin
        dwQ     <= reqAddr[ADDR_W-1:OFF_W];
        offQ    <= reqAddr[OFF_W-1:0];
        sizeQ   <= reqSize;
        revQ    <= reqReverse;
        sextQ   <= reqSignExt;
        isLoadQ <= reqIsLoad;
        dataQ   <= reqData;
      end
      if (strb.keepLo) loPieceQ <= cacheRdData;
      wbValid <= strb.finish;
      if (strb.finish) wbData <= isLoadQ ? loadWord : '0;
    end
  end

  // R8: a zero-extended single-byte load leaves the upper bytes clear
  p_zext_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && isLoadQ && !sextQ && sizeQ == '0) |-> (wbData[DATA_W-1:8] == '0));
  // R5: a second request never reaches the top lane
  p_hi_top_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sendHi |-> !cacheByteEn[LANES-1]);
endmodule

// File: rtl/ls_align_unit.sv
module ls_align_unit
  import ls_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int SZ_W  = $clog2($clog2(LANES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqIsLoad,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SZ_W-1:0]   reqSize,
  input  logic              reqReverse,
  input  logic              reqSignExt,
  input  logic [DATA_W-1:0] reqData,
  output logic              stallOut,
  output logic              cacheValid,
  output logic              cacheIsLoad,
  output logic [ADDR_W-1:0] cacheAddr,
  output logic [LANES-1:0]  cacheByteEn,
  output logic [DATA_W-1:0] cacheWrData,
  input  logic              cacheAck,
  input  logic [DATA_W-1:0] cacheRdData,
  output logic              wbValid,
  output logic [DATA_W-1:0] wbData
);
  lsStrobe_t strb;
  logic      isSplit;

  ls_align_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .isSplit(isSplit),
    .cacheAck(cacheAck), .strb(strb), .stallOut(stallOut), .cacheValid(cacheValid)
  );

  ls_align_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqIsLoad(reqIsLoad), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqReverse(reqReverse), .reqSignExt(reqSignExt),
    .reqData(reqData), .cacheRdData(cacheRdData), .isSplit(isSplit),
    .isLoadQ(cacheIsLoad), .cacheAddr(cacheAddr), .cacheByteEn(cacheByteEn),
    .cacheWrData(cacheWrData), .wbValid(wbValid), .wbData(wbData)
  );

  // R5: consecutive requests go to adjacent doublewords
  p_pair_adjacent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cacheValid && $past(cacheValid)) |-> (cacheAddr == $past(cacheAddr) + ADDR_W'(LANES)));
  // R4: every request enables at least one lane
  p_some_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cacheValid |-> (cacheByteEn != '0));
  // R9: one-cycle write-back, always right after an acknowledgement
  p_wb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |=> !wbValid);
  p_wb_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> $past(cacheAck));
endmodule

// File: tb/sim_ls_align_unit.sv
`timescale 1ns/1ps
module sim_ls_align_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqIsLoad = 1'b0, reqReverse = 1'b0, reqSignExt = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [63:0] reqData = '0;
  logic        stallOut, cacheValid, cacheIsLoad, wbValid;
  logic [31:0] cacheAddr;
  logic [7:0]  cacheByteEn;
  logic [63:0] cacheWrData, wbData;
  logic        cacheAck = 1'b0;
  logic [63:0] cacheRdData = '0;
  int nChecks = 0, nBad = 0;

  always #4 clk = ~clk;

  ls_align_unit u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsLoad(reqIsLoad),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqReverse(reqReverse),
    .reqSignExt(reqSignExt), .reqData(reqData), .stallOut(stallOut),
    .cacheValid(cacheValid), .cacheIsLoad(cacheIsLoad), .cacheAddr(cacheAddr),
    .cacheByteEn(cacheByteEn), .cacheWrData(cacheWrData), .cacheAck(cacheAck),
    .cacheRdData(cacheRdData), .wbValid(wbValid), .wbData(wbData)
  );

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return 8'(a * 32'd29 + (a >> 5) + 32'h3c);
  endfunction

  function automatic logic [63:0] dwWord(input logic [31:0] base);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = memByte(base + 32'(k));
    return w;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runAccess(input bit isLd, input logic [31:0] addr, input int sz,
                           input bit rev, input bit sx, input logic [63:0] data, input int lat);
    int n, off, fin;
    bit split;
    logic [7:0]  be1, be2;
    logic [63:0] st, ld;
    logic [31:0] base;
    n = 1 << sz;
    off = int'(addr[2:0]);
    split = (off + n) > 8;            // R3
    base = {addr[31:3], 3'b000};
    be1 = '0; be2 = '0; st = '0; ld = '0;
    for (int k = 0; k < 8; k++) begin
      int r;
      be1[k] = (k >= off) && (k < off + n);
      be2[k] = k < off + n - 8;
      r = (k - off + 8) % 8;
      if (r < n) st[8*k +: 8] = data[8*(rev ? n - 1 - r : r) +: 8];
    end
    for (int j = 0; j < 8; j++) begin
      if (j < n) ld[8*j +: 8] = memByte(addr + 32'(rev ? n - 1 - j : j));
    end
    for (int j = n; j < 8; j++) ld[8*j +: 8] = {8{sx & ld[8*(n-1)+7]}};
    if (!isLd) ld = '0;
    if (isLd) st = '0;
    fin = split ? lat + 1 : lat;

    @(negedge clk);
    check("R2 idle before request", {63'd0, stallOut}, 64'd0);
    reqValid = 1'b1; reqIsLoad = isLd; reqAddr = addr; reqSize = 2'(sz);
    reqReverse = rev; reqSignExt = sx; reqData = data;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check("R2 stall after accept", {63'd0, stallOut}, 64'd1);
    check("R4 first valid", {62'd0, cacheValid, cacheIsLoad}, {62'd0, 1'b1, isLd});
    check("R4 first address", {32'd0, cacheAddr}, {32'd0, base});
    check("R3 R4 first byte enables", {56'd0, cacheByteEn}, {56'd0, be1});
    check("R6 store data first", cacheWrData, st);
    for (int c = 1; c <= fin + 1; c++) begin
      @(posedge clk); @(negedge clk);
      cacheAck = 1'b0;
      if (c == 1 && split) begin
        check("R5 second valid", {63'd0, cacheValid}, 64'd1);
        check("R5 second address", {32'd0, cacheAddr}, {32'd0, base + 32'd8});
        check("R5 second byte enables", {56'd0, cacheByteEn}, {56'd0, be2});
        check("R6 store data second", cacheWrData, st);
      end else begin
        check("R5 no extra request", {63'd0, cacheValid}, 64'd0);
      end
      if (c <= fin) begin
        check("R9 no early write-back", {63'd0, wbValid}, 64'd0);
        check("R2 stall while busy", {63'd0, stallOut}, 64'd1);
      end else begin
        check("R9 write-back strobe", {63'd0, wbValid}, 64'd1);
        check("R2 stall released", {63'd0, stallOut}, 64'd0);
        check(isLd ? "R7 R8 load result" : "R9 store wb data", wbData, ld);
      end
      if (c == lat) begin
        cacheAck = 1'b1; cacheRdData = dwWord(base);
      end else if (split && c == lat + 1) begin
        cacheAck = 1'b1; cacheRdData = dwWord(base + 32'd8);
      end
    end
    @(negedge clk);
    check("R9 single-cycle write-back", {63'd0, wbValid}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    check("R1 reset outputs held", {61'd0, stallOut, cacheValid, wbValid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", {61'd0, stallOut, cacheValid, wbValid}, 64'd0);
    idx = 0;
    for (int ld = 0; ld < 2; ld++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
          for (int rv = 0; rv < 2; rv++)
            for (int sx = 0; sx < 2; sx++) begin
              logic [31:0] a;
              a = {29'(16 + idx * 3), 3'(off)};
              runAccess(ld[0], a, sz, rv[0], sx[0],
                        64'h8796_a5b4_c3d2_e1f0 ^ {8{8'(idx * 7)}}, 1 + idx % 3);
              idx++;
            end
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule